// File: doc/BRIEF.md
# Banked Memory Cycle Controller with Odd Parity

The controller runs an endless memory cycle of twelve timing pulses, one pulse per clock. At the first pulse it takes a 12-bit address and turns it into a bank and a word offset. The bank is one of three kinds: the writable erasable bank, one of two fixed banks that are always mapped, or a switchable fixed bank named by a bank register. The addressed word is brought into a buffer register. Erasable words arrive earlier than fixed words. The buffer can then be read, and replaced, in a four-pulse window. At the end of every cycle the buffer is written back, whether or not it was changed.

Each word holds 15 data bits and a parity bit, and the count of ones in the word is odd. The parity of every fetched word is checked. A mismatch sets an alarm that stays on until it is cleared. Fixed banks are modelled as read-only content computed from the bank number and the offset. A fixed bank number above the populated count reads as all zeros, so selecting one raises the alarm.

Top module: `mem_cycle_ctl`

## Requirements
- R1: After reset `tp` is 1. It counts 1, 2, …, 12, one step per clock, and returns to 1 after 12.
- R2: The address and the bank selection are captured at the clock edge that ends pulse 1. Changes to `addr` or to the bank register later in the cycle do not affect that cycle's word.
- R3: An erasable word is in the buffer during pulse 6. A fixed word is in the buffer from pulse 7. Both are visible on `rd_data` at pulse 7.
- R4: `rd_data` shows the buffer only while `tp` is 7 to 10, and is 0 otherwise.
- R5: A `buf_wr` sampled while `tp` is 7 to 10 replaces the buffer with {parity, `buf_wdata`}. The parity is bit 15 and gives an odd count of ones. The new word is visible on the next pulse.
- R6: The buffer is written back at the edge that ends pulse 11. A modified erasable word is therefore returned on a later read of the same address.
- R7: Address bits [9:0] give the word offset. Bits [11:10] give the bank: 00 is erasable, 01 is fixed bank 1, 10 is fixed bank 2, and 11 is the bank register's bank. Fixed bank b at offset o holds data {b[4:0], o[9:0]} with odd parity in bit 15. Erasable words start as 16'h8000.
- R8: With code 11, a bank register value of 0, 1 or 2 selects bank 3. After reset the register is 0.
- R9: Write-back never changes a fixed bank. A modified fixed word reads back with its original content.
- R10: Parity is checked at the edge that ends pulse 7. An even count of ones sets `parity_alarm`, which is visible from pulse 8. Fixed banks above NUM_FIXED (default 6) read as 16'h0000.
- R11: `parity_alarm` stays set until `alarm_clr` is sampled high. If a clear and a new mismatch fall on the same edge, the alarm stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timing pulse per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Bank code [11:10] and word offset [9:0] |
| bank_we | input | 1 | Bank register write strobe |
| bank_wdata | input | 5 | Bank register write value |
| buf_wr | input | 1 | Buffer modify strobe, honoured at pulses 7–10 |
| buf_wdata | input | 15 | Data for the buffer modify |
| alarm_clr | input | 1 | Clears the parity alarm |
| tp | output | 4 | Current timing pulse, 1 to 12 |
| rd_data | output | 16 | Buffer word during pulses 7–10, otherwise 0 |
| parity_alarm | output | 1 | Sticky parity mismatch flag |

## Verification
The parity check at the end of pulse 7 and an alarm clear can fall on the same clock edge. The bench provokes this by first clearing the alarm. It then runs a cycle on an unpopulated switchable bank, whose all-zero word has even parity, and holds `alarm_clr` high across pulse 7. The alarm is sampled at pulse 8 and must still be set, because detection has priority. Separate clear-only and idle-cycle steps confirm that the alarm is both clearable and sticky.

// File: rtl/mem_cycle_ctl.sv
module mem_cycle_ctl #(
  parameter int OFS_W     = 10,
  parameter int BANK_W    = 5,
  parameter int NUM_FIXED = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFS_W+1:0]  addr,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_wdata,
  input  logic              buf_wr,
  input  logic [BANK_W+OFS_W-1:0] buf_wdata,
  input  logic              alarm_clr,
  output logic [3:0]        tp,
  output logic [BANK_W+OFS_W:0] rd_data,
  output logic              parity_alarm
);
  localparam int DATA_W = BANK_W + OFS_W;
  localparam int WORD_W = DATA_W + 1;
  localparam int DEPTH  = 1 << OFS_W;

  logic [OFS_W-1:0]  addr_q;
  logic [BANK_W-1:0] bank_q, bank_reg, bank_sw;
  logic [WORD_W-1:0] buf_q, rom_word;
  logic [WORD_W-1:0] eram [DEPTH];
  logic              win;

  initial for (int i = 0; i < DEPTH; i++) eram[i] = {1'b1, {DATA_W{1'b0}}};

  assign win     = (tp >= 4'd7) && (tp <= 4'd10);
  assign rd_data = win ? buf_q : '0;
  assign bank_sw = (bank_reg < BANK_W'(3)) ? BANK_W'(3) : bank_reg;

  always_comb begin
    rom_word = '0;
    if (int'(bank_q) <= NUM_FIXED)
      rom_word = {~^{bank_q, addr_q}, bank_q, addr_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tp           <= 4'd1;
      addr_q       <= '0;
      bank_q       <= '0;
      bank_reg     <= '0;
      buf_q        <= '0;
      parity_alarm <= 1'b0;
    end else begin
      tp <= (tp == 4'd12) ? 4'd1 : tp + 4'd1;
      if (bank_we) bank_reg <= bank_wdata;
      if (tp == 4'd1) begin
        addr_q <= addr[OFS_W-1:0];
        case (addr[OFS_W+1:OFS_W])
          2'b00:   bank_q <= '0;
          2'b01:   bank_q <= BANK_W'(1);
          2'b10:   bank_q <= BANK_W'(2);
          default: bank_q <= bank_sw;
        endcase
      end
      if (tp == 4'd5 && bank_q == '0) buf_q <= eram[addr_q];
      if (tp == 4'd6 && bank_q != '0) buf_q <= rom_word;
      if (win && buf_wr) buf_q <= {~^buf_wdata, buf_wdata};
      if (tp == 4'd7 && !(^buf_q)) parity_alarm <= 1'b1;
      else if (alarm_clr)          parity_alarm <= 1'b0;
    end
  end

  always_ff @(posedge clk)
    if (rst_n && tp == 4'd11 && bank_q == '0) eram[addr_q] <= buf_q;
endmodule

// File: rtl/mem_cycle_ctl_chk.sv
module mem_cycle_ctl_chk #(
  parameter int OFS_W = 10,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        tp,
  input logic [OFS_W-1:0]  addr_q,
  input logic              buf_wr,
  input logic              alarm_clr,
  input logic [WORD_W-1:0] rd_data,
  input logic              parity_alarm
);
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tp != 4'd12) |=> (tp == $past(tp) + 4'd1));
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tp == 4'd12) |=> (tp == 4'd1));
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tp != 4'd1) |=> $stable(addr_q));
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tp < 4'd7 || tp > 4'd10) |-> (rd_data == '0));
  p_mod_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && tp >= 4'd7 && tp <= 4'd9) |=> (^rd_data));
  p_alarm_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(parity_alarm) |-> ($past(tp) == 4'd7));
  p_alarm_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (parity_alarm && !alarm_clr) |=> parity_alarm);
endmodule

bind mem_cycle_ctl mem_cycle_ctl_chk #(.OFS_W(OFS_W), .WORD_W(BANK_W+OFS_W+1)) u_chk (
  .clk(clk), .rst_n(rst_n), .tp(tp), .addr_q(addr_q), .buf_wr(buf_wr),
  .alarm_clr(alarm_clr), .rd_data(rd_data), .parity_alarm(parity_alarm));

// File: tb/mem_cycle_ctl_test.sv
module mem_cycle_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic bank_we = 1'b0, buf_wr = 1'b0, alarm_clr = 1'b0;
  logic [4:0] bank_wdata = '0;
  logic [14:0] buf_wdata = '0;
  logic [3:0] tp;
  logic [15:0] rd_data;
  logic parity_alarm;
  int n_chk = 0, n_bad = 0;
  logic [14:0] model [1024];

  always #5 clk = ~clk;

  mem_cycle_ctl uut (.clk(clk), .rst_n(rst_n), .addr(addr), .bank_we(bank_we),
    .bank_wdata(bank_wdata), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .alarm_clr(alarm_clr), .tp(tp), .rd_data(rd_data), .parity_alarm(parity_alarm));

  // fields: [32:21] addr, [20:16] bank register, [15] modify, [14:0] data
  localparam logic [32:0] VEC [10] = '{
    {12'h005, 5'd0, 1'b1, 15'h1234},
    {12'h005, 5'd0, 1'b0, 15'h0000},
    {12'h7FF, 5'd0, 1'b0, 15'h0000},
    {12'h923, 5'd0, 1'b0, 15'h0000},
    {12'hC10, 5'd5, 1'b0, 15'h0000},
    {12'hC10, 5'd1, 1'b0, 15'h0000},
    {12'h422, 5'd0, 1'b1, 15'h7FFF},
    {12'h422, 5'd0, 1'b0, 15'h0000},
    {12'h3FF, 5'd0, 1'b1, 15'h0000},
    {12'h3FF, 5'd0, 1'b0, 15'h0000}
  };

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wait_tp(int n);
    do @(negedge clk); while (tp != 4'(n));
  endtask

  function automatic logic [15:0] exp_word(logic [11:0] a, logic [4:0] b);
    logic [4:0] bk;
    logic [9:0] o = a[9:0];
    case (a[11:10])
      2'b00: return {~^model[o], model[o]};
      2'b01: bk = 5'd1;
      2'b10: bk = 5'd2;
      default: bk = (b < 5'd3) ? 5'd3 : b;
    endcase
    if (bk > 5'd6) return 16'h0000;
    return {~^{bk, o}, bk, o};
  endfunction

  task automatic run(logic [11:0] a, logic [4:0] b, logic wr, logic [14:0] wd,
                     logic clr7, output logic [15:0] r7, output logic al8);
    logic [15:0] v;
    wait_tp(12); bank_we = 1'b1; bank_wdata = b;
    wait_tp(1);  bank_we = 1'b0; addr = a;
    wait_tp(2);  addr = ~a; bank_wdata = ~b;
    wait_tp(6);  check("R4 gated before window", rd_data, 16'h0000);
    wait_tp(7);  r7 = rd_data;
    if (wr) begin buf_wr = 1'b1; buf_wdata = wd; end
    if (clr7) alarm_clr = 1'b1;
    wait_tp(8);  buf_wr = 1'b0; alarm_clr = 1'b0; al8 = parity_alarm;
    if (wr) check("R5 modified buffer", rd_data, {~^wd, wd});
    wait_tp(11); v = rd_data;
    check("R4 gated after window", v, 16'h0000);
  endtask

  initial begin
    logic [15:0] r; logic al;
    for (int i = 0; i < 1024; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset tp", {12'h0, tp}, 16'd1);
    check("R11 reset alarm", {15'h0, parity_alarm}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first step", {12'h0, tp}, 16'd2);
    for (int k = 0; k < 10; k++) begin
      logic [11:0] a; logic [4:0] b; logic wr; logic [14:0] wd;
      {a, b, wr, wd} = VEC[k];
      run(a, b, wr, wd, 1'b0, r, al);
      check($sformatf("R3 R7 R8 R9 R6 R2 read vector %0d", k), r, exp_word(a, b));
      if (wr && a[11:10] == 2'b00) model[a[9:0]] = wd;
    end
    check("R10 no alarm on good words", {15'h0, parity_alarm}, 16'h0);
    run(12'hC00, 5'd9, 1'b0, 15'h0, 1'b0, r, al);
    check("R10 unpopulated bank reads zero", r, 16'h0000);
    check("R10 alarm raised", {15'h0, al}, 16'h1);
    run(12'hC10, 5'd2, 1'b0, 15'h0, 1'b0, r, al);
    check("R8 bank 2 maps to 3", r, exp_word(12'hC10, 5'd2));
    check("R11 alarm sticky", {15'h0, parity_alarm}, 16'h1);
    @(negedge clk); alarm_clr = 1'b1;
    @(negedge clk); alarm_clr = 1'b0;
    check("R11 alarm cleared", {15'h0, parity_alarm}, 16'h0);
    run(12'hC00, 5'd9, 1'b0, 15'h0, 1'b1, r, al);
    check("R11 detection beats clear", {15'h0, al}, 16'h1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule